// File: doc/BRIEF.md
# ISA I/O Window Address Translator

This block sits between a processor memory bus and an ISA-style I/O bus. It claims an 8 MB window of processor address space that starts at 0x80000000. It turns every access that lands in that window into a 16-bit I/O port request. The request also carries the transfer size, the write strobe and write data. Read data comes back from the I/O side and is returned to the processor with a one-cycle ready pulse.

Two layouts of the window are supported, and a one-bit map-type register selects between them. In contiguous layout the window behaves as a flat 64 KB port space. In packed layout each 4 KB page of the window maps to a group of 32 ports. The port is formed from the page number and the lowest five address bits. The processor is big-endian, so halfword and word transfers have their byte lanes reordered in both directions. Decoding of the devices behind the ports is left to the I/O bus.

Top module: `isa_io_window`

## Requirements
- R1: A request with address in [0x80000000, 0x807FFFFF] raises `io_sel` for exactly one cycle, in the cycle after the request, with `io_we` and `io_size` copied from the request.
- R2: A request outside that range never raises `io_sel`, and no `cpu_ready` pulse follows it.
- R3: With the map-type bit at 0, `io_port` equals address bits [15:0].
- R4: With the map-type bit at 1, `io_port` equals {address[22:12], address[4:0]}, the same value as (addr & 0x1F) | ((addr & 0x007FF000) >> 7).
- R5: A write to the map-type register keeps only bit 0 of the written byte. Reading the register returns 7'b0 followed by that bit, and it resets to 0.
- R6: For size code 0 (byte), `io_wdata` is the low byte of `cpu_wdata` zero-extended, with no reordering.
- R7: For size code 1 (halfword), the two low bytes are swapped in both directions, zero-extended to 32 bits. For example, write data 0x1234 becomes 0x3412, and read data 0xBEEF becomes 0xEFBE.
- R8: For size code 2 (word), all four bytes are reversed in both directions. For example, 0x11223344 becomes 0x44332211.
- R9: `cpu_ready` pulses for one cycle in the cycle after `io_sel`, for reads and for writes. For a read, `cpu_rdata` then holds the reordered `io_rdata` sampled while `io_sel` was high. For a write, `cpu_rdata` is 0.
- R10: After reset, `io_sel` and `cpu_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Processor write data, right-aligned |
| cpu_rdata | output | 32 | Read data returned to the processor |
| cpu_ready | output | 1 | One-cycle completion pulse |
| map_wr | input | 1 | Write strobe of the map-type register |
| map_wdata | input | 8 | Byte written to the map-type register |
| map_rdata | output | 8 | Map-type register readback |
| io_sel | output | 1 | I/O request valid |
| io_we | output | 1 | I/O write |
| io_size | output | 2 | I/O transfer size |
| io_port | output | 16 | Translated port address |
| io_wdata | output | 32 | Lane-ordered write data |
| io_rdata | input | 32 | Read data from the I/O side |

## Verification
The I/O-side request fields are due one clock edge after the processor request is sampled. `cpu_ready` and `cpu_rdata` are due one edge after that. Map-type readback is due one edge after the register write. The bench drives inputs on falling edges and samples on the following falling edge, so each result is checked in its own cycle. For the same reason, read data is supplied only during the cycle in which `io_sel` is high.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    localparam int DATA_W = 32;
    localparam int PORT_W = 16;

    typedef struct packed {
        logic               we;
        xfer_size_e         size;
        logic [PORT_W-1:0]  port;
        logic [DATA_W-1:0]  data;
    } io_req_t;

    // Big-endian lane ordering; byte and narrower results are zero-extended.
    function automatic logic [DATA_W-1:0] order_lanes(
        input logic [DATA_W-1:0] d,
        input xfer_size_e        sz,
        input logic              swap
    );
        logic [DATA_W-1:0] r;
        case (sz)
            SZ_BYTE: r = {24'h0, d[7:0]};
            SZ_HALF: r = swap ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
            default: r = swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/isa_win_map_reg.sv
module isa_win_map_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic       mode,
    output logic [7:0] rd_byte
);
    always_ff @(posedge clk) begin
        if (rst)        mode <= 1'b0;
        else if (wr_en) mode <= wr_byte[0];
    end

    assign rd_byte = {7'h0, mode};

    assert_map_store_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_byte == {7'h0, $past(wr_byte[0])}));
endmodule

// File: rtl/isa_win_xlate.sv
module isa_win_xlate #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_LOG2   = 23,
    parameter int          PAGE_SHIFT = 12,
    parameter int          LOW_BITS   = 5,
    parameter int          PORT_W     = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              packed_mode,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int PAGE_W = WIN_LOG2 - PAGE_SHIFT;
    localparam int TAG_W  = ADDR_W - WIN_LOG2;

    logic [PORT_W-1:0] flat_port;
    logic [PORT_W-1:0] pack_port;

    assign hit       = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1 -: TAG_W]);
    assign flat_port = addr[PORT_W-1:0];

    generate
        if (PAGE_W + LOW_BITS == PORT_W) begin : g_exact
            assign pack_port = {addr[WIN_LOG2-1:PAGE_SHIFT], addr[LOW_BITS-1:0]};
        end else begin : g_pad
            logic [PAGE_W+LOW_BITS-1:0] raw;
            assign raw       = {addr[WIN_LOG2-1:PAGE_SHIFT], addr[LOW_BITS-1:0]};
            assign pack_port = PORT_W'(raw);
        end
    endgenerate

    assign port = packed_mode ? pack_port : flat_port;
endmodule

// File: rtl/isa_win_lanes.sv
module isa_win_lanes
    import isa_win_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  xfer_size_e        size,
    output logic [DATA_W-1:0] dout
);
    generate
        if (BIG_ENDIAN) begin : g_swap
            assign dout = order_lanes(din, size, 1'b1);
        end else begin : g_pass
            assign dout = order_lanes(din, size, 1'b0);
        end
    endgenerate
endmodule

// File: rtl/isa_io_window.sv
module isa_io_window
    import isa_win_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_LOG2   = 23,
    parameter bit          BIG_ENDIAN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_ready,
    input  logic        map_wr,
    input  logic [7:0]  map_wdata,
    output logic [7:0]  map_rdata,
    output logic        io_sel,
    output logic        io_we,
    output logic [1:0]  io_size,
    output logic [15:0] io_port,
    output logic [31:0] io_wdata,
    input  logic [31:0] io_rdata
);
    localparam int TAG_W = 32 - WIN_LOG2;

    logic              mode;
    logic              hit;
    logic [PORT_W-1:0] port_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] rdata_c;
    io_req_t           req_q;
    logic              sel_q;
    logic              rdy_q;
    logic [DATA_W-1:0] rdata_q;

    isa_win_map_reg u_map (
        .clk(clk), .rst(rst), .wr_en(map_wr), .wr_byte(map_wdata),
        .mode(mode), .rd_byte(map_rdata)
    );

    isa_win_xlate #(.WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .PORT_W(PORT_W)) u_xlate (
        .addr(cpu_addr), .packed_mode(mode), .hit(hit), .port(port_c)
    );

    isa_win_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_wlanes (
        .din(cpu_wdata), .size(xfer_size_e'(cpu_size)), .dout(wdata_c)
    );

    isa_win_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_rlanes (
        .din(io_rdata), .size(req_q.size), .dout(rdata_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            req_q <= '0;
        end else begin
            sel_q <= cpu_req && hit;
            if (cpu_req && hit) begin
                req_q.we   <= cpu_we;
                req_q.size <= xfer_size_e'(cpu_size);
                req_q.port <= port_c;
                req_q.data <= cpu_we ? wdata_c : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rdy_q <= sel_q;
            if (sel_q) rdata_q <= req_q.we ? '0 : rdata_c;
        end
    end

    assign io_sel    = sel_q;
    assign io_we     = req_q.we;
    assign io_size   = req_q.size;
    assign io_port   = req_q.port;
    assign io_wdata  = req_q.data;
    assign cpu_ready = rdy_q;
    assign cpu_rdata = rdata_q;

    assert_hit_issue_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_addr[31:WIN_LOG2] == WIN_BASE[31 -: TAG_W]) |=> io_sel);

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[31:WIN_LOG2] != WIN_BASE[31 -: TAG_W]) |=> !io_sel);

    assert_sel_single_R1: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |=> !io_sel);

    assert_flat_port_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && map_rdata[0] == 1'b0) |=> (!io_sel || io_port == $past(cpu_addr[15:0])));

    assert_ready_after_R9: assert property (@(posedge clk) disable iff (rst)
        io_sel |=> cpu_ready);

    assert_ready_only_R9: assert property (@(posedge clk) disable iff (rst)
        !io_sel |=> !cpu_ready);

    generate
        if (BIG_ENDIAN) begin : g_chk_be
            assert_word_rev_R8: assert property (@(posedge clk) disable iff (rst)
                (cpu_req && cpu_we && cpu_size == 2'd2) |=>
                (!io_sel || io_wdata == {$past(cpu_wdata[7:0]), $past(cpu_wdata[15:8]),
                                         $past(cpu_wdata[23:16]), $past(cpu_wdata[31:24])}));
        end
    endgenerate
endmodule

// File: tb/isa_io_window_bench.sv
module isa_io_window_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we, map_wr;
    logic [31:0] cpu_addr, cpu_wdata, io_rdata;
    logic [1:0]  cpu_size;
    logic [7:0]  map_wdata;
    logic [31:0] cpu_rdata, io_wdata;
    logic        cpu_ready, io_sel, io_we;
    logic [7:0]  map_rdata;
    logic [1:0]  io_size;
    logic [15:0] io_port;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    isa_io_window u_isa_io_window (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .map_wr(map_wr),
        .map_wdata(map_wdata), .map_rdata(map_rdata), .io_sel(io_sel),
        .io_we(io_we), .io_size(io_size), .io_port(io_port),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic set_map(input logic [7:0] b);
        @(negedge clk);
        map_wr = 1'b1; map_wdata = b;
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    // One access: request sampled at edge 1, io_* due after it, ready after edge 2.
    task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] rd,
                          input logic [15:0] exp_port, input logic [31:0] exp_wd,
                          input logic [31:0] exp_rd, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0; io_rdata = rd;
        chk(io_sel == 1'b1, {tag, " R1 sel"}, 32'(io_sel), 32'd1);
        chk(io_we == we && io_size == sz, {tag, " R1 we/size"}, {29'd0, io_we, io_size}, {29'd0, we, sz});
        chk(io_port == exp_port, {tag, " port"}, 32'(io_port), 32'(exp_port));
        if (we) chk(io_wdata == exp_wd, {tag, " wdata"}, io_wdata, exp_wd);
        @(negedge clk);
        io_rdata = 32'h0;
        chk(io_sel == 1'b0, {tag, " R1 single"}, 32'(io_sel), 32'd0);
        chk(cpu_ready == 1'b1, {tag, " R9 ready"}, 32'(cpu_ready), 32'd1);
        chk(cpu_rdata == exp_rd, {tag, " R9 rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        chk(cpu_ready == 1'b0, {tag, " R9 pulse"}, 32'(cpu_ready), 32'd0);
    endtask

    task automatic miss(input logic [31:0] a, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = 1'b1; cpu_size = 2'd0; cpu_wdata = 32'h55;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(io_sel == 1'b0, {tag, " R2 no sel"}, 32'(io_sel), 32'd0);
        @(negedge clk);
        chk(cpu_ready == 1'b0, {tag, " R2 no ready"}, 32'(cpu_ready), 32'd0);
    endtask

    task automatic t_reset;
        chk(io_sel == 1'b0, "R10 sel", 32'(io_sel), 0);
        chk(cpu_ready == 1'b0, "R10 ready", 32'(cpu_ready), 0);
        chk(map_rdata == 8'h00, "R5 reset", 32'(map_rdata), 0);
    endtask

    task automatic t_map;
        set_map(8'hFF);
        chk(map_rdata == 8'h01, "R5 store bit0", 32'(map_rdata), 32'h01);
        set_map(8'hFE);
        chk(map_rdata == 8'h00, "R5 drop upper", 32'(map_rdata), 32'h00);
    endtask

    task automatic t_flat;
        access(32'h8000_03F8, 1'b1, 2'd0, 32'hAABBCC5A, 0, 16'h03F8, 32'h5A, 0, "R3 R6 byte");
        access(32'h8012_3456, 1'b0, 2'd0, 0, 32'h0000_0077, 16'h3456, 0, 32'h77, "R3 offset");
        access(32'h807F_FFFF, 1'b0, 2'd0, 0, 32'h0000_0011, 16'hFFFF, 0, 32'h11, "R1 top");
    endtask

    task automatic t_packed;
        set_map(8'h01);
        access(32'h8012_3456, 1'b1, 2'd0, 32'h9, 0, 16'h2476, 32'h9, 0, "R4 packed");
        access(32'h807F_F01F, 1'b0, 2'd0, 0, 32'h3, 16'hFFFF, 0, 32'h3, "R4 top");
        set_map(8'h00);
    endtask

    task automatic t_lanes;
        access(32'h8000_0100, 1'b1, 2'd1, 32'hFFFF1234, 0, 16'h0100, 32'h3412, 0, "R7 hw wr");
        access(32'h8000_0102, 1'b0, 2'd1, 0, 32'h0000BEEF, 16'h0102, 0, 32'hEFBE, "R7 hw rd");
        access(32'h8000_0200, 1'b1, 2'd2, 32'h11223344, 0, 16'h0200, 32'h44332211, 0, "R8 w wr");
        access(32'h8000_0204, 1'b0, 2'd2, 0, 32'hCAFEF00D, 16'h0204, 0, 32'h0DF0FECA, "R8 w rd");
    endtask

    task automatic t_miss;
        miss(32'h7FFF_FFFC, "below");
        miss(32'h8080_0000, "above");
    endtask

    initial begin
        rst = 1'b1; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_size = 0;
        cpu_wdata = 0; map_wr = 0; map_wdata = 0; io_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_map;
        t_flat;
        t_packed;
        t_lanes;
        t_miss;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule